// File: doc/BRIEF.md
# Multi-Ratio Framed Serial Deserializer

This block collects one serial bit stream, clocked by a fast bit-rate enable, into parallel words that are framed against a slow reference clock. That slow clock reaches the block as a single-cycle word strobe. The strobe is only honoured in a cycle that also carries a bit, and the bit taken in that cycle is the first bit after the slow edge. The block supports three word widths (4, 7 and 8 bits) and a bypass mode. In bypass it passes one bit for each slow cycle and the serial-to-parallel path is not used.

In normal framing each word begins two bit times before the slow edge, which allows for clock insertion delay. The two bits just ahead of the strobe therefore become the two most significant bits of the next word. In calibration framing this offset is removed and a word starts with the bit taken at the strobe. Bits are shifted in MSB first. Each finished word goes into a holding register and is announced by a one-cycle valid pulse. When the width or framing selection changes, the new setting is applied at the next strobe, and the first word built under it is not announced. A system with sixteen channels at width 8 places one instance per channel and obtains 128 parallel bits per slow cycle.

Top module: `ds_deser`

## Requirements
- R1: `ratio_sel` sets the word width: 2'b01 gives 4 bits, 2'b10 gives 7 bits, 2'b11 gives 8 bits, and 2'b00 selects bypass with a width of 1.
- R2: In bypass, the bit taken in each strobe cycle appears on `word_out[0]` one cycle later, together with a one-cycle `word_vld`.
- R3: The first bit of a word that is received lands in `word_out[N-1]` and the last one lands in `word_out[0]`, where N is the width.
- R4: With `cal_sel`=0, a word is made of the last two bits taken before a strobe followed by the first N-2 bits taken from the strobe bit onward. It completes on bit N-3 counted from the strobe.
- R5: With `cal_sel`=1, a word is made of the N bits that start at the strobe bit.
- R6: `word_vld` is high for exactly the one cycle after the bit that completes a word, once per frame. At all other times `word_out` keeps its value.
- R7: For widths below 8, the output bits at and above the width read zero whenever a word is announced.
- R8: `ratio_sel` and `cal_sel` are sampled only in a strobe cycle. After reset, or after a strobe that brings a different width or framing, the first word that completes is not announced and `word_out` does not change for it.
- R9: While reset is active, `word_out` is zero and `word_vld` is low.
- R10: Cycles with `bit_en` low have no effect, even when they carry a strobe, serial data or selection values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bit_en | input | 1 | Marks a cycle that carries one serial bit |
| frame_stb | input | 1 | Slow-clock edge marker, honoured only together with `bit_en` |
| ser_in | input | 1 | Serial data bit |
| ratio_sel | input | 2 | Width selection (see R1) |
| cal_sel | input | 1 | 1 selects calibration framing with no two-bit offset |
| word_out | output | 8 | Held parallel word, MSB first |
| word_vld | output | 1 | One-cycle pulse when a new word is in `word_out` |

## Verification
The hardest behaviour to reach from the ports is the way normal framing depends on the previous frame. A word straddles two strobes, and if the selection changes at the strobe in between, the word must be dropped. The stimulus therefore runs through every width and framing in a sequence where each run differs from the one before it. Junk selection values are driven on every non-strobe bit, and gapped runs put a strobe on idle cycles. This way a wrongly timed sample or an unsuppressed first word produces a word that the bench can check against its arithmetic expectation built from the bits on both sides of the strobe.

// File: rtl/ds_pkg.sv
package ds_pkg;

  localparam int unsigned DS_MAX_W = 8;

  typedef enum logic [1:0] {
    RATIO_X1 = 2'b00,
    RATIO_X4 = 2'b01,
    RATIO_X7 = 2'b10,
    RATIO_X8 = 2'b11
  } ratio_e;

  // Serial bits per word for each selection.
  function automatic int word_len(ratio_e r);
    case (r)
      RATIO_X4: return 4;
      RATIO_X7: return 7;
      RATIO_X8: return 8;
      default:  return 1;
    endcase
  endfunction

endpackage

// File: rtl/ds_rst_sync.sv
module ds_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);

  logic [STAGES-1:0] sync_r;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_r <= '0;
    else         sync_r <= {sync_r[STAGES-2:0], 1'b1};
  end

  assign rst_n = sync_r[STAGES-1];

endmodule

// File: rtl/ds_frame_ctl.sv
module ds_frame_ctl
  import ds_pkg::*;
#(
  parameter int unsigned POS_W = 4
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   bit_en,
  input  logic   frame_stb,
  input  ratio_e ratio_sel,
  input  logic   cal_sel,
  output logic   complete,
  output logic   suppress,
  output ratio_e frame_ratio,
  output ratio_e held_ratio,
  output logic   held_cal
);

  localparam logic [POS_W-1:0] POS_SAT = '1;

  logic [POS_W-1:0] pos_r, pos_d, cur_pos, target;
  ratio_e           ratio_r, ratio_d;
  logic             cal_r, cal_d, eff_cal;
  logic             loaded_r, loaded_d;
  logic             skip_r, skip_d;
  logic             upd, changed;
  int               len;

  always_comb begin
    upd         = bit_en & frame_stb;
    frame_ratio = upd ? ratio_sel : ratio_r;
    eff_cal     = upd ? cal_sel : cal_r;
    len         = word_len(frame_ratio);

    if (frame_ratio == RATIO_X1) target = '0;
    else if (eff_cal)            target = POS_W'(len - 1);
    else                         target = POS_W'(len - 3);

    if (upd)                   cur_pos = '0;
    else if (pos_r == POS_SAT) cur_pos = pos_r;
    else                       cur_pos = pos_r + 1'b1;

    changed  = upd & (~loaded_r | (ratio_sel != ratio_r) | (cal_sel != cal_r));
    complete = bit_en & (cur_pos == target);
    suppress = skip_r | changed;

    pos_d    = bit_en ? cur_pos : pos_r;
    ratio_d  = frame_ratio;
    cal_d    = eff_cal;
    loaded_d = loaded_r | upd;

    if (changed)       skip_d = ~complete;
    else if (complete) skip_d = 1'b0;
    else               skip_d = skip_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_r    <= POS_SAT;
      ratio_r  <= RATIO_X8;
      cal_r    <= 1'b0;
      loaded_r <= 1'b0;
      skip_r   <= 1'b1;
    end else begin
      pos_r    <= pos_d;
      ratio_r  <= ratio_d;
      cal_r    <= cal_d;
      loaded_r <= loaded_d;
      skip_r   <= skip_d;
    end
  end

  assign held_ratio = ratio_r;
  assign held_cal   = cal_r;

endmodule

// File: rtl/ds_word_asm.sv
module ds_word_asm
  import ds_pkg::*;
#(
  parameter int unsigned MAX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             ser_in,
  input  logic             complete,
  input  logic             suppress,
  input  ratio_e           frame_ratio,
  output logic [MAX_W-1:0] word_out,
  output logic             word_vld
);

  logic [MAX_W-2:0] sh_r, sh_d;
  logic [MAX_W-1:0] full, masked, word_r, word_d;
  logic             vld_r, vld_d;
  logic             take;

  assign full = {sh_r, ser_in};

  // Clear every lane at or above the active width.
  for (genvar g = 0; g < int'(MAX_W); g++) begin : g_lane
    assign masked[g] = full[g] & (g < word_len(frame_ratio));
  end

  always_comb begin
    take   = complete & ~suppress;
    sh_d   = bit_en ? full[MAX_W-2:0] : sh_r;
    word_d = take ? masked : word_r;
    vld_d  = take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_r   <= '0;
      word_r <= '0;
      vld_r  <= 1'b0;
    end else begin
      sh_r   <= sh_d;
      word_r <= word_d;
      vld_r  <= vld_d;
    end
  end

  assign word_out = word_r;
  assign word_vld = vld_r;

endmodule

// File: rtl/ds_deser.sv
module ds_deser
  import ds_pkg::*;
#(
  parameter int unsigned MAX_W       = DS_MAX_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             bit_en,
  input  logic             frame_stb,
  input  logic             ser_in,
  input  logic [1:0]       ratio_sel,
  input  logic             cal_sel,
  output logic [MAX_W-1:0] word_out,
  output logic             word_vld
);

  localparam int unsigned POS_W = $clog2(MAX_W) + 1;

  logic   rst_n_s;
  logic   complete, suppress;
  ratio_e frame_ratio, held_ratio;
  logic   held_cal;

  ds_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (arst_n),
    .rst_n  (rst_n_s)
  );

  ds_frame_ctl #(.POS_W(POS_W)) u_ctl (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .bit_en      (bit_en),
    .frame_stb   (frame_stb),
    .ratio_sel   (ratio_e'(ratio_sel)),
    .cal_sel     (cal_sel),
    .complete    (complete),
    .suppress    (suppress),
    .frame_ratio (frame_ratio),
    .held_ratio  (held_ratio),
    .held_cal    (held_cal)
  );

  ds_word_asm #(.MAX_W(MAX_W)) u_asm (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .bit_en      (bit_en),
    .ser_in      (ser_in),
    .complete    (complete),
    .suppress    (suppress),
    .frame_ratio (frame_ratio),
    .word_out    (word_out),
    .word_vld    (word_vld)
  );

endmodule

// File: rtl/ds_deser_chk.sv
module ds_deser_chk #(
  parameter int unsigned MAX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_en,
  input logic             frame_stb,
  input logic             ser_in,
  input logic [1:0]       ratio_sel,
  input logic             cal_sel,
  input logic [MAX_W-1:0] word_out,
  input logic             word_vld,
  input logic [1:0]       held_ratio,
  input logic             held_cal
);

  assert_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |-> ((held_ratio == 2'b00) ? (word_out[MAX_W-1:1] == '0) :
                  (held_ratio == 2'b01) ? (word_out[MAX_W-1:4] == '0) :
                  (held_ratio == 2'b10) ? (word_out[MAX_W-1:7] == '0) : 1'b1));

  assert_bypass_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld && held_ratio == 2'b00) |-> ($past(frame_stb) && word_out[0] == $past(ser_in)));

  assert_vld_after_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |-> $past(bit_en));

  assert_hold_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !word_vld |-> $stable(word_out));

  assert_change_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && frame_stb && (ratio_sel != held_ratio || cal_sel != held_cal)) |=> !word_vld);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> !word_vld);

endmodule

bind ds_deser ds_deser_chk #(.MAX_W(MAX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n_s),
  .bit_en     (bit_en),
  .frame_stb  (frame_stb),
  .ser_in     (ser_in),
  .ratio_sel  (ratio_sel),
  .cal_sel    (cal_sel),
  .word_out   (word_out),
  .word_vld   (word_vld),
  .held_ratio (held_ratio),
  .held_cal   (held_cal)
);

// File: tb/sim_ds_deser.sv
`timescale 1ns/1ps
module sim_ds_deser;

  logic       clk = 1'b0;
  logic       arst_n, bit_en, frame_stb, ser_in, cal_sel;
  logic [1:0] ratio_sel;
  logic [7:0] word_out;
  logic       word_vld;
  logic [7:0] last_w;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  ds_deser u0 (
    .clk(clk), .arst_n(arst_n), .bit_en(bit_en), .frame_stb(frame_stb),
    .ser_in(ser_in), .ratio_sel(ratio_sel), .cal_sel(cal_sel),
    .word_out(word_out), .word_vld(word_vld)
  );

  function automatic logic bv(int r, int k, int i);
    logic [31:0] h;
    h = 32'(r * 1000 + k * 16 + i + 7) * 32'h9E3779B1;
    return h[17] ^ h[5] ^ h[29];
  endfunction

  function automatic int lenof(logic [1:0] rs);
    case (rs)
      2'b01:   return 4;
      2'b10:   return 7;
      2'b11:   return 8;
      default: return 1;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    arst_n = 1'b0; bit_en = 1'b0; frame_stb = 1'b0; ser_in = 1'b0;
    ratio_sel = 2'b00; cal_sel = 1'b0;
    @(negedge clk);
    check(word_out == 8'h00, "R9 reset word", word_out, 8'h00);
    check(word_vld == 1'b0, "R9 reset valid", {7'b0, word_vld}, 8'h00);
    repeat (2) @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    last_w = 8'h00;
  endtask

  // One run: `frames` frames with one width and framing; idle cycles with junk between bits.
  task automatic run(input int r, input logic [1:0] rs, input logic cs, input int frames, input int gap);
    int    n, tgt;
    bit    normal;
    string tag;
    n      = lenof(rs);
    normal = (rs != 2'b00) && !cs;
    tgt    = (rs == 2'b00) ? 0 : (cs ? n - 1 : n - 3);
    tag    = (rs == 2'b00) ? "R2 bypass" : (normal ? "R4 R3 R1 normal" : "R5 R3 R1 calibration");
    for (int k = 0; k < frames; k++) begin
      for (int i = 0; i < n; i++) begin
        logic [7:0] w;
        bit         exp_v;
        bit_en    = 1'b1;
        frame_stb = (i == 0);
        ser_in    = bv(r, k, i);
        ratio_sel = (i == 0) ? rs : ~rs;
        cal_sel   = (i == 0) ? cs : ~cs;
        @(posedge clk);
        @(negedge clk);
        w = 8'h00;
        for (int j = 0; j < n; j++) begin
          logic src;
          if (normal) src = (j < 2) ? bv(r, k - 1, n - 2 + j) : bv(r, k, j - 2);
          else        src = bv(r, k, j);
          w[n - 1 - j] = src;
        end
        exp_v = (i == tgt) && (k > 0);
        if (i == tgt && k == 0) begin
          check(word_vld == 1'b0, "R8 first word after change dropped", {7'b0, word_vld}, 8'h00);
          check(word_out == last_w, "R8 word kept", word_out, last_w);
        end else if (exp_v) begin
          check(word_vld == 1'b1, {"R6 pulse ", tag}, {7'b0, word_vld}, 8'h01);
          check(word_out == w, tag, word_out, w);
          check((word_out >> n) == 8'h00, "R7 upper bits zero", word_out, w);
          last_w = w;
        end else begin
          check(word_vld == 1'b0, "R6 no pulse", {7'b0, word_vld}, 8'h00);
          check(word_out == last_w, "R6 hold", word_out, last_w);
        end
        for (int g = 0; g < gap; g++) begin
          bit_en    = 1'b0;
          frame_stb = 1'b1;
          ser_in    = ~ser_in;
          ratio_sel = ~rs;
          cal_sel   = ~cs;
          @(posedge clk);
          @(negedge clk);
          check(word_vld == 1'b0, "R10 idle no pulse", {7'b0, word_vld}, 8'h00);
          check(word_out == last_w, "R10 idle hold", word_out, last_w);
        end
      end
    end
  endtask

  initial begin
    arst_n = 1'b0; bit_en = 1'b0; frame_stb = 1'b0; ser_in = 1'b0;
    ratio_sel = 2'b00; cal_sel = 1'b0; last_w = 8'h00;
    do_reset();
    run(1,  2'b00, 1'b0, 6, 0);
    run(2,  2'b01, 1'b0, 6, 0);
    run(3,  2'b01, 1'b1, 6, 0);
    run(4,  2'b10, 1'b0, 6, 0);
    run(5,  2'b10, 1'b1, 6, 0);
    run(6,  2'b11, 1'b0, 6, 0);
    run(7,  2'b11, 1'b1, 6, 0);
    run(8,  2'b11, 1'b0, 5, 2);
    run(9,  2'b00, 1'b0, 5, 1);
    run(10, 2'b01, 1'b0, 5, 1);
    run(11, 2'b10, 1'b0, 4, 0);
    do_reset();
    run(12, 2'b10, 1'b0, 4, 0);
    run(13, 2'b01, 1'b1, 4, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R6 watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule